// File: doc/BRIEF.md
# Coherent Sampling-Ratio Register Pair

This block presents a 16-bit input-to-output sampling ratio to a host as two byte-wide, read-only registers. The ratio has a 5-bit integer part and an 11-bit fractional part. A measurement circuit outside the block drives it continuously on the same clock as the register port.

The ratio is wider than one host access, so a plain two-byte read could pair a high byte from one measurement with a low byte from the next. To prevent this, a read of the high-byte address returns the live high byte and, in the same access, captures the live low byte into a snapshot. A later read of the low-byte address returns that snapshot and not the live value. Software reads the high address first, then the low address, and gets a matched pair.

Read data and its valid flag are registered. A strobe sampled on one rising edge shows up on `rd_data`/`rd_valid` after that edge.

Top module: `ratio_readout`

## Requirements
- R1: After synchronous reset, `rd_data` is 0, `rd_valid` is 0, and the low-byte snapshot is 0, so a low-byte read issued before any high-byte read returns 0.
- R2: A read strobe at address HI_ADDR (default 6) returns, after the sampling edge, the byte {int[4:0], frac[10:8]} taken from the live ratio on that edge. The integer part is in bits 7..3.
- R3: A high-byte read captures live frac[7:0] on the same edge. A later low-byte read at LO_ADDR (default 7) returns that captured byte even if the live ratio has changed since.
- R4: A low-byte read with no high-byte read since the last capture returns the previous snapshot unchanged. Repeated low-byte reads return the same byte.
- R5: A write strobe (`wr_en` without `rd_en`) to either address has no effect. It changes neither `rd_data` nor the snapshot.
- R6: A read strobe at any address other than HI_ADDR and LO_ADDR returns 0.
- R7: `rd_valid` is 1 in exactly the cycle after each read strobe and 0 in every other cycle.
- R8: When there is no read strobe, `rd_data` holds its last value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Register clock |
| rst | input | 1 | Synchronous active-high reset |
| live_int | input | 5 | Integer part of the live ratio |
| live_frac | input | 11 | Fractional part of the live ratio |
| rd_en | input | 1 | Read strobe, one cycle per access |
| wr_en | input | 1 | Write strobe, ignored by the registers |
| addr | input | 4 | Register address |
| rd_data | output | 8 | Registered read data |
| rd_valid | output | 1 | Read data valid, one cycle after the strobe |

## Verification
The assertions assume that the live ratio is synchronous to `clk` and settled before each rising edge. They also assume that every read is a single-cycle strobe with a stable address. The bench changes `live_int`, `live_frac`, `addr` and the strobes only on falling edges, so every value is held across the sampling edge. It changes the live ratio between the high-byte read and the low-byte read to expose any tearing. It also issues back-to-back reads, write strobes, and reads of unmapped addresses, all within the strobe rules above.

// File: rtl/ratio_pkg.sv
package ratio_pkg;
  localparam int INT_W_DEF  = 5;
  localparam int FRAC_W_DEF = 11;
  localparam int BYTE_W_DEF = 8;
  localparam int ADDR_W_DEF = 4;

  typedef enum logic [2:0] {
    ACC_IDLE,
    ACC_RD_HI,
    ACC_RD_LO,
    ACC_RD_OTHER,
    ACC_WRITE
  } access_e;
endpackage

// File: rtl/ratio_addr_decode.sv
module ratio_addr_decode
  import ratio_pkg::*;
#(
  parameter int ADDR_W  = ADDR_W_DEF,
  parameter int HI_ADDR = 6,
  parameter int LO_ADDR = 7
) (
  input  logic              rd_en,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] addr,
  output access_e           kind
);
  localparam logic [ADDR_W-1:0] HI_A = ADDR_W'(HI_ADDR);
  localparam logic [ADDR_W-1:0] LO_A = ADDR_W'(LO_ADDR);

  always_comb begin
    kind = ACC_IDLE;
    if (rd_en) begin
      if (addr == HI_A)      kind = ACC_RD_HI;
      else if (addr == LO_A) kind = ACC_RD_LO;
      else                   kind = ACC_RD_OTHER;
    end else if (wr_en) begin
      kind = ACC_WRITE;
    end
  end
endmodule

// File: rtl/ratio_snapshot.sv
module ratio_snapshot
  import ratio_pkg::*;
#(
  parameter int SNAP_W = BYTE_W_DEF
) (
  input  logic              clk,
  input  logic              rst,
  input  access_e           kind,
  input  logic [SNAP_W-1:0] live_lo,
  output logic [SNAP_W-1:0] snap_lo
);
  always_ff @(posedge clk) begin
    if (rst)                    snap_lo <= '0;
    else if (kind == ACC_RD_HI) snap_lo <= live_lo;
  end

  // R3: capture on the high-byte read
  p_capture_r3: assert property (@(posedge clk) disable iff (rst)
    kind == ACC_RD_HI |=> snap_lo == $past(live_lo));
  // R4, R5: any other access leaves the snapshot alone
  p_hold_r4: assert property (@(posedge clk) disable iff (rst)
    kind != ACC_RD_HI |=> $stable(snap_lo));
endmodule

// File: rtl/ratio_read_port.sv
module ratio_read_port
  import ratio_pkg::*;
#(
  parameter int BYTE_W = BYTE_W_DEF
) (
  input  logic              clk,
  input  logic              rst,
  input  access_e           kind,
  input  logic [BYTE_W-1:0] live_hi,
  input  logic [BYTE_W-1:0] snap_lo,
  output logic [BYTE_W-1:0] rd_data,
  output logic              rd_valid
);
  logic rd_hit;
  assign rd_hit = (kind == ACC_RD_HI) || (kind == ACC_RD_LO) || (kind == ACC_RD_OTHER);

  always_ff @(posedge clk) begin
    if (rst) begin
      rd_data  <= '0;
      rd_valid <= 1'b0;
    end else begin
      rd_valid <= rd_hit;
      case (kind)
        ACC_RD_HI:    rd_data <= live_hi;
        ACC_RD_LO:    rd_data <= snap_lo;
        ACC_RD_OTHER: rd_data <= '0;
        default:      rd_data <= rd_data;
      endcase
    end
  end

  // R6: unmapped read yields zero
  p_unmapped_zero_r6: assert property (@(posedge clk) disable iff (rst)
    kind == ACC_RD_OTHER |=> rd_data == '0);
  // R8: no read, data held
  p_idle_hold_r8: assert property (@(posedge clk) disable iff (rst)
    !rd_hit |=> $stable(rd_data));
endmodule

// File: rtl/ratio_readout.sv
module ratio_readout
  import ratio_pkg::*;
#(
  parameter int INT_W   = INT_W_DEF,
  parameter int FRAC_W  = FRAC_W_DEF,
  parameter int BYTE_W  = BYTE_W_DEF,
  parameter int ADDR_W  = ADDR_W_DEF,
  parameter int HI_ADDR = 6,
  parameter int LO_ADDR = 7
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [INT_W-1:0]  live_int,
  input  logic [FRAC_W-1:0] live_frac,
  input  logic              rd_en,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] addr,
  output logic [BYTE_W-1:0] rd_data,
  output logic              rd_valid
);
  localparam int RATIO_W   = INT_W + FRAC_W;
  localparam int HI_FRAC_W = RATIO_W - BYTE_W - INT_W + (BYTE_W - (RATIO_W - BYTE_W));
  localparam int HF_W      = BYTE_W - INT_W;

  logic [RATIO_W-1:0] live_ratio;
  logic [BYTE_W-1:0]  live_hi;
  logic [BYTE_W-1:0]  live_lo;
  logic [BYTE_W-1:0]  snap_lo;
  access_e            kind;

  assign live_ratio = {live_int, live_frac};
  assign live_hi    = live_ratio[RATIO_W-1 -: BYTE_W];
  assign live_lo    = live_ratio[BYTE_W-1:0];

  ratio_addr_decode #(
    .ADDR_W(ADDR_W), .HI_ADDR(HI_ADDR), .LO_ADDR(LO_ADDR)
  ) u_dec (
    .rd_en(rd_en), .wr_en(wr_en), .addr(addr), .kind(kind)
  );

  ratio_snapshot #(.SNAP_W(BYTE_W)) u_snap (
    .clk(clk), .rst(rst), .kind(kind), .live_lo(live_lo), .snap_lo(snap_lo)
  );

  ratio_read_port #(.BYTE_W(BYTE_W)) u_port (
    .clk(clk), .rst(rst), .kind(kind), .live_hi(live_hi),
    .snap_lo(snap_lo), .rd_data(rd_data), .rd_valid(rd_valid)
  );

  // R2: high read returns integer bits on top, upper fraction bits below
  p_hi_fresh_r2: assert property (@(posedge clk) disable iff (rst)
    rd_en && addr == ADDR_W'(HI_ADDR) |=>
      rd_data == {$past(live_int), $past(live_frac[FRAC_W-1 -: HF_W])});
  // R3: high then low read pairs match the ratio at the high read
  p_pair_coherent_r3: assert property (@(posedge clk) disable iff (rst)
    rd_en && addr == ADDR_W'(HI_ADDR) ##1 rd_en && addr == ADDR_W'(LO_ADDR) |=>
      rd_data == $past(live_frac[BYTE_W-1:0], 2));
  // R5: a lone write leaves the read data untouched
  p_write_ignored_r5: assert property (@(posedge clk) disable iff (rst)
    wr_en && !rd_en |=> $stable(rd_data));
  // R7: valid follows the read strobe by one cycle
  p_valid_follows_r7: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> rd_valid == $past(rd_en));
  // R1: out of reset the outputs are cleared
  p_reset_clear_r1: assert property (@(posedge clk)
    rst |=> rd_data == '0 && !rd_valid);

  logic unused_w;
  assign unused_w = ^HI_FRAC_W[0];
endmodule

// File: tb/tb_ratio_readout.sv
module tb_ratio_readout;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [4:0] live_int = '0;
  logic [10:0] live_frac = '0;
  logic       rd_en = 1'b0;
  logic       wr_en = 1'b0;
  logic [3:0] addr = '0;
  logic [7:0] rd_data;
  logic       rd_valid;

  int checks = 0;
  int failures = 0;
  logic [7:0] model_lo = '0;
  logic [7:0] exp_q[$];
  string      tag_q[$];
  bit         done = 0;

  always #10 clk = ~clk;

  ratio_readout dut (
    .clk(clk), .rst(rst), .live_int(live_int), .live_frac(live_frac),
    .rd_en(rd_en), .wr_en(wr_en), .addr(addr),
    .rd_data(rd_data), .rd_valid(rd_valid)
  );

  task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic set_live(input logic [15:0] v);
    live_int  = v[15:11];
    live_frac = v[10:0];
  endtask

  task automatic do_read(input logic [3:0] a, input string tag);
    logic [7:0] e;
    if (a == 4'd6) begin
      e = {live_int, live_frac[10:8]};
      model_lo = live_frac[7:0];
    end else if (a == 4'd7) e = model_lo;
    else e = 8'h00;
    rd_en = 1'b1; addr = a;
    exp_q.push_back(e); tag_q.push_back(tag);
    @(negedge clk);
    rd_en = 1'b0;
  endtask

  task automatic do_write(input logic [3:0] a);
    wr_en = 1'b1; addr = a;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  // monitor / scoreboard
  always @(negedge clk) begin
    if (!rst) begin
      if (rd_valid) begin
        if (exp_q.size() == 0) begin
          checks++; failures++;
          $display("FAIL R7 actual=valid expected=no_valid");
        end else begin
          automatic logic [7:0] e = exp_q.pop_front();
          automatic string t = tag_q.pop_front();
          check(t, rd_data, e);
        end
      end else if (exp_q.size() > 1) begin
        checks++; failures++;
        $display("FAIL R7 actual=no_valid expected=valid");
      end
    end
  end

  // watchdog
  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    logic [7:0] held;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    check("R1 rd_data", rd_data, 8'h00);
    check("R1 rd_valid", {7'b0, rd_valid}, 8'h00);
    set_live(16'hABCD);
    do_read(4'd7, "R1 lo before capture");
    @(negedge clk);

    // R2 / R3: capture, change live, read low
    set_live(16'b10110_101_11001110);
    do_read(4'd6, "R2 hi byte");
    set_live(16'h1234);
    do_read(4'd7, "R3 lo after live change");
    @(negedge clk);

    // R4: repeated low reads with changing live
    set_live(16'hFFFF);
    do_read(4'd7, "R4 lo repeat 1");
    set_live(16'h0001);
    do_read(4'd7, "R4 lo repeat 2");
    @(negedge clk);

    // R2 extremes
    set_live(16'hFFFF);
    do_read(4'd6, "R2 hi all ones");
    set_live(16'h0000);
    do_read(4'd7, "R3 lo all ones");
    do_read(4'd6, "R2 hi zero");
    do_read(4'd7, "R3 lo zero");
    @(negedge clk);

    // R5: writes ignored
    set_live(16'h5A5A);
    do_read(4'd6, "R2 hi 5A");
    @(negedge clk);
    held = rd_data;
    set_live(16'hC3C3);
    do_write(4'd6);
    check("R5 rd_data after write hi", rd_data, held);
    do_write(4'd7);
    check("R5 rd_data after write lo", rd_data, held);
    do_read(4'd7, "R5 snapshot after writes");
    @(negedge clk);

    // R6: unmapped addresses
    do_read(4'd0, "R6 addr 0");
    do_read(4'd6, "R2 hi before unmapped");
    do_read(4'd15, "R6 addr 15");
    @(negedge clk);

    // R8: hold with no strobe
    held = rd_data;
    set_live(16'h7777);
    repeat (3) @(negedge clk);
    check("R8 hold", rd_data, held);
    check("R7 no valid when idle", {7'b0, rd_valid}, 8'h00);

    repeat (3) @(negedge clk);
    check("R7 queue drained", 8'(exp_q.size()), 8'h00);
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule